// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers interrupt events from up to sixteen peripheral sources into a 16-bit status register and gates them with a 16-bit mask register. It drives one level-sensitive pending line to the CPU. Each source input is a single-cycle pulse that latches its status bit. The DMA controller's completion event has its own input, which lands on status bit 3.

Software reads and writes both registers over a simple single-cycle register bus. Writing the status register acknowledges interrupts: the written word is ANDed into the register, so a 0 clears that bit and a 1 leaves it alone. Writing the mask register replaces it. After every status write, mask write or source event the pending line is recomputed and shows whether any bit is both set and unmasked.

Top module: `irq_status_mask`

## Requirements
- R1: A write to the status register (offset 0x70) leaves the status equal to the old status ANDed with bits [15:0] of the write data, so only bits written as 0 are cleared.
- R2: `irqPending` is 1 exactly when the status register ANDed with the mask register is nonzero, and is 0 otherwise.
- R3: After a status write clears the last set-and-unmasked bit, `irqPending` is 0 on the following cycle. If any unmasked bit remains set, it stays 1.
- R4: A write to the mask register (offset 0x74) replaces the mask with bits [15:0] of the write data, and the next cycle's `irqPending` is evaluated against the current status and the new mask.
- R5: Both registers accept a full 32-bit write word. Only bits [15:0] take effect and bits [31:16] are ignored, so 16-bit and 32-bit stores behave the same.
- R6: A pulse on `dmaDone` sets status bit 3.
- R7: A pulse on `srcPulse[i]` sets status bit i. If an acknowledge write clears bit i in the same cycle, the set wins and the bit ends up 1.
- R8: A read returns the 16-bit register selected by offset 0x70 or 0x74 on `busRdata[15:0]`, with bits [31:16] zero. Any other offset reads 0 and ignores writes. Reads change no state.
- R9: While `rst` is high at a clock edge, status, mask and `irqPending` are all cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busSel | input | 1 | Register access strobe for this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset: 0x70 status, 0x74 mask |
| busWdata | input | 32 | Write data; only bits [15:0] used |
| busRdata | output | 32 | Read data, zero-extended, combinational |
| srcPulse | input | 16 | Per-bit single-cycle source events |
| dmaDone | input | 1 | DMA controller event, sets status bit 3 |
| irqPending | output | 1 | Level output: an unmasked interrupt is pending |

## Verification
The bench aims at an acknowledge write that lands in the same cycle as a new event on the same bit. A design that let the write win would drop that interrupt for good. It clears the last unmasked bit while masked bits stay set, which catches a pending line computed from the status alone. It also unmasks an already-set bit to catch a design that only re-evaluates on status changes. Writes with ones in the upper half word, and writes to unused offsets, expose designs that let those bits or addresses disturb the registers.

// File: rtl/irq_sm_pkg.sv
package irq_sm_pkg;
  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic wrStatus;
    logic wrMask;
  } regStrobe_t;

  // Which register feeds the read mux
  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_STATUS = 2'd1,
    RD_MASK   = 2'd2
  } rdSel_t;
endpackage

// File: rtl/irq_sm_ctrl.sv
module irq_sm_ctrl
  import irq_sm_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int STATUS_OFS = 'h70,
  parameter int MASK_OFS   = 'h74
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strobe,
  output rdSel_t            rdSel
);
  localparam logic [ADDR_W-1:0] StatusAddr = ADDR_W'(STATUS_OFS);
  localparam logic [ADDR_W-1:0] MaskAddr   = ADDR_W'(MASK_OFS);

  logic hitStatus;
  logic hitMask;

  always_comb begin
    hitStatus = busAddr == StatusAddr;
    hitMask   = busAddr == MaskAddr;

    strobe.wrStatus = busSel && busWr && hitStatus;
    strobe.wrMask   = busSel && busWr && hitMask;

    if (hitStatus)    rdSel = RD_STATUS;
    else if (hitMask) rdSel = RD_MASK;
    else              rdSel = RD_NONE;
  end
endmodule

// File: rtl/irq_sm_datapath.sv
module irq_sm_datapath
  import irq_sm_pkg::*;
#(
  parameter int NSRC    = 16,
  parameter int DMA_BIT = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  regStrobe_t      strobe,
  input  rdSel_t          rdSel,
  input  logic [NSRC-1:0] wrValue,
  input  logic [NSRC-1:0] srcPulse,
  input  logic            dmaDone,
  output logic [NSRC-1:0] statusQ,
  output logic [NSRC-1:0] maskQ,
  output logic [NSRC-1:0] rdValue,
  output logic            irqPending
);
  logic [NSRC-1:0] setVec;
  logic [NSRC-1:0] statusNext;
  logic [NSRC-1:0] maskNext;

  // Per-bit event merge: the DMA event shares its assigned bit
  for (genvar i = 0; i < NSRC; i++) begin : g_set
    if (i == DMA_BIT) begin : g_dma
      assign setVec[i] = srcPulse[i] | dmaDone;
    end else begin : g_plain
      assign setVec[i] = srcPulse[i];
    end
  end

  always_comb begin
    // Acknowledge by AND; a new event in the same cycle wins
    statusNext = strobe.wrStatus ? (statusQ & wrValue) : statusQ;
    statusNext = statusNext | setVec;
    maskNext   = strobe.wrMask ? wrValue : maskQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statusQ    <= '0;
      maskQ      <= '0;
      irqPending <= 1'b0;
    end else begin
      statusQ    <= statusNext;
      maskQ      <= maskNext;
      irqPending <= |(statusNext & maskNext);
    end
  end

  always_comb begin
    unique case (rdSel)
      RD_STATUS: rdValue = statusQ;
      RD_MASK:   rdValue = maskQ;
      default:   rdValue = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_mask.sv
module irq_status_mask
  import irq_sm_pkg::*;
#(
  parameter int NSRC       = 16,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int DMA_BIT    = 3,
  parameter int STATUS_OFS = 'h70,
  parameter int MASK_OFS   = 'h74
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [NSRC-1:0]   srcPulse,
  input  logic              dmaDone,
  output logic              irqPending
);
  localparam int PadW = DATA_W - NSRC;

  regStrobe_t      strobe;
  rdSel_t          rdSel;
  logic [NSRC-1:0] statusQ;
  logic [NSRC-1:0] maskQ;
  logic [NSRC-1:0] rdValue;
  logic [PadW-1:0] unusedHigh;

  irq_sm_ctrl #(
    .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS), .MASK_OFS(MASK_OFS)
  ) u_ctrl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .strobe(strobe), .rdSel(rdSel)
  );

  irq_sm_datapath #(.NSRC(NSRC), .DMA_BIT(DMA_BIT)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .rdSel(rdSel),
    .wrValue(busWdata[NSRC-1:0]), .srcPulse(srcPulse), .dmaDone(dmaDone),
    .statusQ(statusQ), .maskQ(maskQ), .rdValue(rdValue),
    .irqPending(irqPending)
  );

  // Upper half of the write word has no effect on either register
  assign unusedHigh = busWdata[DATA_W-1:NSRC];
  assign busRdata   = {{PadW{1'b0}}, rdValue};
endmodule

// File: rtl/irq_status_mask_chk.sv
module irq_status_mask_chk #(
  parameter int NSRC    = 16,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int DMA_BIT = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic [NSRC-1:0]   srcPulse,
  input logic              dmaDone,
  input logic [NSRC-1:0]   statusQ,
  input logic [NSRC-1:0]   maskQ,
  input logic              irqPending
);
  logic wrSt;
  logic wrMk;
  assign wrSt = busSel && busWr && busAddr == ADDR_W'('h70);
  assign wrMk = busSel && busWr && busAddr == ADDR_W'('h74);

  // R1: acknowledge is an AND when no event arrives
  p_ack_and_r1: assert property (@(posedge clk) disable iff (rst)
    (wrSt && srcPulse == '0 && !dmaDone)
      |=> statusQ == $past(statusQ & busWdata[NSRC-1:0]));

  // R2 / R3: pending tracks status AND mask
  p_pending_r2: assert property (@(posedge clk) disable iff (rst)
    irqPending == |(statusQ & maskQ));

  // R4: mask write replaces mask
  p_mask_load_r4: assert property (@(posedge clk) disable iff (rst)
    wrMk |=> maskQ == $past(busWdata[NSRC-1:0]));

  // R7: an event bit is always set next cycle, even under a same-cycle ack
  p_src_set_r7: assert property (@(posedge clk) disable iff (rst)
    (srcPulse != '0) |=> (statusQ & $past(srcPulse)) == $past(srcPulse));

  // R6: DMA event sets its bit
  p_dma_set_r6: assert property (@(posedge clk) disable iff (rst)
    dmaDone |=> statusQ[DMA_BIT]);

  // R8: bits above the register width read as zero
  p_zero_ext_r8: assert property (@(posedge clk) disable iff (rst)
    busRdata[DATA_W-1:NSRC] == '0);

  // R8: idle cycles change nothing
  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (!(busSel && busWr) && srcPulse == '0 && !dmaDone)
      |=> $stable(statusQ) && $stable(maskQ));

  // R9: reset clears everything
  p_reset_r9: assert property (@(posedge clk)
    rst |=> statusQ == '0 && maskQ == '0 && !irqPending);
endmodule

bind irq_status_mask irq_status_mask_chk #(
  .NSRC(NSRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DMA_BIT(DMA_BIT)
) u_chk (
  .clk(clk), .rst(rst), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .srcPulse(srcPulse),
  .dmaDone(dmaDone), .statusQ(statusQ), .maskQ(maskQ),
  .irqPending(irqPending)
);

// File: tb/sim_irq_status_mask.sv
`timescale 1ns/1ps
module sim_irq_status_mask;
  logic        clk = 1'b0;
  logic        rst;
  logic        busSel;
  logic        busWr;
  logic [7:0]  busAddr;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic [15:0] srcPulse;
  logic        dmaDone;
  logic        irqPending;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // Behavioural reference state
  int refStatus = 0;
  int refMask   = 0;

  always #2 clk = ~clk;

  irq_status_mask u0 (
    .clk(clk), .rst(rst), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .srcPulse(srcPulse),
    .dmaDone(dmaDone), .irqPending(irqPending)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000 && !done) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected < 5000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int refRead(input logic [7:0] a);
    if (a == 8'h70) return refStatus;
    if (a == 8'h74) return refMask;
    return 0;
  endfunction

  // Drive one cycle, update the model at the edge, compare at the next negedge
  task automatic step(input logic sel, input logic wr, input logic [7:0] a,
                      input logic [31:0] wd, input logic [15:0] src,
                      input logic dma, input logic r, input string tag);
    int st;
    int expPend;
    int expRd;
    busSel = sel; busWr = wr; busAddr = a; busWdata = wd;
    srcPulse = src; dmaDone = dma; rst = r;
    @(posedge clk);
    if (r) begin
      refStatus = 0; refMask = 0;
    end else begin
      st = refStatus;
      if (sel && wr && a == 8'h70) st = st & int'(wd[15:0]);
      st = st | int'(src) | (dma ? 8 : 0);
      if (sel && wr && a == 8'h74) refMask = int'(wd[15:0]);
      refStatus = st;
    end
    @(negedge clk);
    expPend = ((refStatus & refMask) != 0) ? 1 : 0;
    expRd   = refRead(a);
    checks = checks + 1;
    if (int'(irqPending) != expPend) begin
      fails = fails + 1;
      $display("FAIL %s irqPending got %0d expected %0d", tag, irqPending, expPend);
    end
    checks = checks + 1;
    if (busRdata != 32'(expRd)) begin
      fails = fails + 1;
      $display("FAIL %s busRdata got %h expected %h", tag, busRdata, 32'(expRd));
    end
  endtask

  initial begin
    busSel = 0; busWr = 0; busAddr = 0; busWdata = 0; srcPulse = 0;
    dmaDone = 0; rst = 1;
    @(negedge clk);
    step(0, 0, 8'h70, 0, 16'h0000, 0, 1, "R9 reset");
    step(0, 0, 8'h74, 0, 16'h0000, 0, 0, "R9 mask after reset");
    // R7: sources set bits, nothing pending while masked
    step(0, 0, 8'h70, 0, 16'h0011, 0, 0, "R7 set bits 0,4");
    step(0, 0, 8'h70, 0, 16'h8000, 0, 0, "R7 set bit 15");
    // R4: unmask an already-set bit
    step(1, 1, 8'h74, 32'h0000_0010, 0, 0, 0, "R4 unmask bit 4");
    step(1, 0, 8'h74, 0, 0, 0, 0, "R8 read mask");
    // R1 / R3: ack bit 4 -> pending drops, other bits remain
    step(1, 1, 8'h70, 32'h0000_FFEF, 0, 0, 0, "R3 ack last unmasked");
    step(1, 0, 8'h70, 0, 0, 0, 0, "R1 status after ack");
    // R6: DMA event lands on bit 3
    step(0, 0, 8'h70, 0, 0, 1, 0, "R6 dma event");
    step(1, 1, 8'h74, 32'h0000_0008, 0, 0, 0, "R6 unmask dma bit");
    // R3: ack with ones keeps pending
    step(1, 1, 8'h70, 32'h0000_FFFF, 0, 0, 0, "R3 ack writing ones");
    // R7: set wins over same-cycle ack
    step(1, 1, 8'h70, 32'h0000_0000, 16'h0008, 0, 0, "R7 set beats ack");
    step(1, 0, 8'h70, 0, 0, 0, 0, "R7 status after race");
    // R5: upper half ignored on both registers
    step(1, 1, 8'h74, 32'hFFFF_0001, 0, 0, 0, "R5 mask upper ignored");
    step(1, 1, 8'h70, 32'h0000_FFF7, 16'h0001, 0, 0, "R5 status narrow ack");
    step(1, 1, 8'h70, 32'hFFFF_FFFE, 0, 0, 0, "R5 wide ack upper ignored");
    // R8: unmapped offsets read zero and ignore writes
    step(1, 1, 8'h78, 32'h0000_0000, 0, 0, 0, "R8 unmapped write");
    step(1, 0, 8'h70, 0, 0, 0, 0, "R8 status untouched");
    step(1, 0, 8'h00, 0, 0, 0, 0, "R8 unmapped read");
    step(1, 0, 8'h70, 0, 0, 0, 0, "R8 read no side effect");
    // R2: several patterns of status and mask
    for (int k = 0; k < 40; k++) begin
      step(k % 3 == 0, k % 2 == 0, (k % 4 < 2) ? 8'h70 : 8'h74,
           {16'hA5A5, 16'(k * 16'h3B1D)}, 16'(k * 16'h0907), k % 5 == 0, 0,
           "R2 mixed pattern");
    end
    step(1, 1, 8'h74, 32'h0000_0000, 0, 0, 0, "R4 mask all off");
    step(0, 0, 8'h70, 0, 0, 0, 1, "R9 reset again");
    step(1, 0, 8'h70, 0, 0, 0, 0, "R9 status cleared");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule